// File: doc/BRIEF.md
# Video Field Writer Control Register Bank

This block is the software-facing register bank of a video field-writing engine. A host on a simple 32-bit register bus programs the engine's run mode, buffer count, base address and the strides between buffers and between lines. These values are held in a staging copy. They reach the engine's live configuration outputs only after the host writes the commit register. If the engine is idle at that write, the values apply on the next cycle. If a field is being written, they apply at the next start-of-field strobe. A pending flag tells software that staged values are still waiting to be applied.

The datapath reports each field's progress with start-of-field and end-of-field strobes, plus a line-completion strobe that carries the line index. At end of field it also presents the field's start address, width, height and second-field flag. The bank captures these values into a set of buffer-information registers and raises a buffer-available flag. The captured set stays frozen until software writes the acknowledge register. The acknowledge takes effect at once and does not go through the commit path. The bank also keeps a count of completed buffers and two enabled interrupt sources, which are combined onto a single interrupt line.

Top module: `vfw_ctrl_regs`

## Requirements
- R1: The staged registers are run mode at 0x10 (bits 1:0), buffer count at 0x14 (bits 23:0), base address at 0x18, buffer stride at 0x1C and line stride at 0x20. A write to one of them changes only its readback value and not the `act_*` outputs. A write of any value to 0x28 (commit) copies all staged values to the `act_*` outputs. This happens one cycle later if the engine is idle at the commit write. If a field is in progress, it happens on the next `fld_sof` strobe instead.
- R2: Bit 1 of the status word at 0x04 (pending) becomes 1 after any write to a staged register. It returns to 0 when the staged values are applied. A staged write made in the same cycle as an apply keeps it at 1.
- R3: Bit 0 of the status word at 0x04 (busy) becomes 1 after `fld_sof` and 0 after `fld_eof`. It resets to 0.
- R4: On `fld_eof` while buffer-available (bit 0 of 0x30) is 0, the bank sets buffer-available and captures the field inputs. The address is read at 0x34, the width at 0x38, the height at 0x3C and the second-field flag at bit 0 of 0x40. While buffer-available is 1, later fields leave these registers unchanged.
- R5: A write of any value to 0x2C (acknowledge) clears buffer-available on the next cycle, with no commit needed. If `fld_eof` arrives in the same cycle as the acknowledge, that field is captured and buffer-available stays 1.
- R6: Register 0x08 holds the interrupt enables: bit 0 for field completion and bit 1 for line match. Register 0x24 holds the line number to match. A flag bit in 0x0C is set when its event occurs while it is enabled. The line event is `line_done` with `line_idx` equal to the match value. Writing 1 to a flag bit clears it, and an event in the same cycle wins over the clear. `irq` is 1 when any flag bit is set together with its enable bit.
- R7: The buffer write counter at 0x44 increments on each `fld_eof`. It becomes 0 after any write to the commit register.
- R8: Address 0x00 always reads 0x5A1703C1: product code 0x03C1 in bits 15:0 and vendor code 0x5A17 in bits 31:16.
- R9: Unmapped addresses, including 0x48 and above and addresses that are not word-aligned, read as zero. Writes to them change no state and do not raise pending. The commit and acknowledge registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| fld_sof | input | 1 | Start-of-field strobe |
| fld_eof | input | 1 | End-of-field strobe |
| line_done | input | 1 | A line write has completed |
| line_idx | input | LINE_W | Index of the completed line |
| fld_addr | input | 32 | Start address of the finishing field |
| fld_width | input | DIM_W | Width of the finishing field |
| fld_height | input | DIM_W | Height of the finishing field |
| fld_f1 | input | 1 | Finishing field is a second field |
| act_run_mode | output | 2 | Applied run mode |
| act_buf_count | output | 24 | Applied buffer count |
| act_base | output | 32 | Applied base address |
| act_buf_stride | output | 32 | Applied buffer stride |
| act_line_stride | output | 32 | Applied line stride |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are checked. The first is an acknowledge write in the same cycle as an end-of-field strobe. The buffer-available flag must stay set, and the information registers must show the new field rather than the older frozen one. The second is a commit written during a field. The configuration outputs must hold through the end of the field and change exactly on the following start-of-field strobe. Both cases are driven as directed cycles, and they also come up inside a long random mix of bus and strobe events. After every cycle, a bench reference model predicts every readable register and output, and the bench compares them against the design.

// File: rtl/vfw_ctrl_pkg.sv
package vfw_ctrl_pkg;

    localparam int unsigned BUFCNT_W = 24;
    localparam logic [31:0] ID_WORD = 32'h5A17_03C1;

    // register byte offsets
    localparam int unsigned A_ID      = 'h00;
    localparam int unsigned A_STAT    = 'h04;
    localparam int unsigned A_IRQ_EN  = 'h08;
    localparam int unsigned A_IRQ_FLG = 'h0C;
    localparam int unsigned A_RUN     = 'h10;
    localparam int unsigned A_BUFCNT  = 'h14;
    localparam int unsigned A_BASE    = 'h18;
    localparam int unsigned A_BSTRIDE = 'h1C;
    localparam int unsigned A_LSTRIDE = 'h20;
    localparam int unsigned A_MARK    = 'h24;
    localparam int unsigned A_COMMIT  = 'h28;
    localparam int unsigned A_ACK     = 'h2C;
    localparam int unsigned A_AVAIL   = 'h30;
    localparam int unsigned A_INF_ADR = 'h34;
    localparam int unsigned A_INF_WID = 'h38;
    localparam int unsigned A_INF_HGT = 'h3C;
    localparam int unsigned A_INF_F1  = 'h40;
    localparam int unsigned A_WRCOUNT = 'h44;

    typedef struct packed {
        logic [1:0]          run_mode;
        logic [BUFCNT_W-1:0] buf_count;
        logic [31:0]         base;
        logic [31:0]         buf_stride;
        logic [31:0]         line_stride;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_RUN,
        SEL_COUNT,
        SEL_BASE,
        SEL_BSTRIDE,
        SEL_LSTRIDE
    } stage_sel_e;

endpackage

// File: rtl/vfw_shadow_cfg.sv
module vfw_shadow_cfg
    import vfw_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stage_wr,
    input  stage_sel_e  stage_sel,
    input  logic [31:0] wdata,
    input  logic        commit_wr,
    input  logic        engine_busy,
    input  logic        sof,
    output cfg_t        shadow,
    output cfg_t        active,
    output logic        pending
);

    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
        logic pending;
        logic armed;
    } state_t;

    state_t st_d, st_q;
    logic   apply_now;

    always_comb begin
        st_d      = st_q;
        apply_now = (commit_wr && !engine_busy) || (sof && st_q.armed);

        if (commit_wr && engine_busy) begin
            st_d.armed = 1'b1;
        end

        if (apply_now) begin
            st_d.active  = st_q.shadow;
            st_d.pending = 1'b0;
            st_d.armed   = 1'b0;
        end

        if (stage_wr) begin
            st_d.pending = 1'b1;
            case (stage_sel)
                SEL_RUN:     st_d.shadow.run_mode    = wdata[1:0];
                SEL_COUNT:   st_d.shadow.buf_count   = wdata[BUFCNT_W-1:0];
                SEL_BASE:    st_d.shadow.base        = wdata;
                SEL_BSTRIDE: st_d.shadow.buf_stride  = wdata;
                SEL_LSTRIDE: st_d.shadow.line_stride = wdata;
                default:     st_d.pending            = st_q.pending;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow  = st_q.shadow;
    assign active  = st_q.active;
    assign pending = st_q.pending;

endmodule

// File: rtl/vfw_field_track.sv
module vfw_field_track #(
    parameter int unsigned DIM_W = 16,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic             ack_wr,
    input  logic             commit_wr,
    input  logic [31:0]      fld_addr,
    input  logic [DIM_W-1:0] fld_width,
    input  logic [DIM_W-1:0] fld_height,
    input  logic             fld_f1,
    output logic             busy,
    output logic             avail,
    output logic [31:0]      info_addr,
    output logic [DIM_W-1:0] info_width,
    output logic [DIM_W-1:0] info_height,
    output logic             info_f1,
    output logic [CNT_W-1:0] wr_count
);

    typedef struct packed {
        logic             busy;
        logic             avail;
        logic [31:0]      addr;
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
        logic             f1;
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (sof) st_d.busy = 1'b1;
        if (eof) st_d.busy = 1'b0;

        if (ack_wr) st_d.avail = 1'b0;
        if (eof && (!st_q.avail || ack_wr)) begin
            st_d.avail  = 1'b1;
            st_d.addr   = fld_addr;
            st_d.width  = fld_width;
            st_d.height = fld_height;
            st_d.f1     = fld_f1;
        end

        if (eof) st_d.count = st_q.count + 1'b1;
        if (commit_wr) st_d.count = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign avail       = st_q.avail;
    assign info_addr   = st_q.addr;
    assign info_width  = st_q.width;
    assign info_height = st_q.height;
    assign info_f1     = st_q.f1;
    assign wr_count    = st_q.count;

endmodule

// File: rtl/vfw_irq_ctrl.sv
module vfw_irq_ctrl #(
    parameter int unsigned LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              clr_wr,
    input  logic              mark_wr,
    input  logic [31:0]       wdata,
    input  logic              field_done,
    input  logic              line_done,
    input  logic [LINE_W-1:0] line_idx,
    output logic [1:0]        irq_en,
    output logic [1:0]        irq_flags,
    output logic [LINE_W-1:0] line_mark,
    output logic              irq
);

    typedef struct packed {
        logic [1:0]        en;
        logic [1:0]        flags;
        logic [LINE_W-1:0] mark;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr)   st_d.en    = wdata[1:0];
        if (mark_wr) st_d.mark  = wdata[LINE_W-1:0];
        if (clr_wr)  st_d.flags = st_q.flags & ~wdata[1:0];
        if (field_done && st_q.en[0]) st_d.flags[0] = 1'b1;
        if (line_done && st_q.en[1] && (line_idx == st_q.mark)) st_d.flags[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_en    = st_q.en;
    assign irq_flags = st_q.flags;
    assign line_mark = st_q.mark;
    assign irq       = |(st_q.flags & st_q.en);

endmodule

// File: rtl/vfw_ctrl_regs.sv
module vfw_ctrl_regs
    import vfw_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIM_W  = 16,
    parameter int unsigned LINE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                fld_sof,
    input  logic                fld_eof,
    input  logic                line_done,
    input  logic [LINE_W-1:0]   line_idx,
    input  logic [31:0]         fld_addr,
    input  logic [DIM_W-1:0]    fld_width,
    input  logic [DIM_W-1:0]    fld_height,
    input  logic                fld_f1,
    output logic [1:0]          act_run_mode,
    output logic [BUFCNT_W-1:0] act_buf_count,
    output logic [31:0]         act_base,
    output logic [31:0]         act_buf_stride,
    output logic [31:0]         act_line_stride,
    output logic                irq
);

    localparam int unsigned CNT_W = 32;

    // write decode
    logic       stage_wr, commit_wr, ack_wr, en_wr, clr_wr, mark_wr;
    stage_sel_e stage_sel;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        stage_sel = SEL_RUN;
        stage_wr  = 1'b0;
        if (reg_wr) begin
            if (hit(reg_addr, A_RUN))     begin stage_wr = 1'b1; stage_sel = SEL_RUN;     end
            if (hit(reg_addr, A_BUFCNT))  begin stage_wr = 1'b1; stage_sel = SEL_COUNT;   end
            if (hit(reg_addr, A_BASE))    begin stage_wr = 1'b1; stage_sel = SEL_BASE;    end
            if (hit(reg_addr, A_BSTRIDE)) begin stage_wr = 1'b1; stage_sel = SEL_BSTRIDE; end
            if (hit(reg_addr, A_LSTRIDE)) begin stage_wr = 1'b1; stage_sel = SEL_LSTRIDE; end
        end
    end

    assign commit_wr = reg_wr && hit(reg_addr, A_COMMIT);
    assign ack_wr    = reg_wr && hit(reg_addr, A_ACK);
    assign en_wr     = reg_wr && hit(reg_addr, A_IRQ_EN);
    assign clr_wr    = reg_wr && hit(reg_addr, A_IRQ_FLG);
    assign mark_wr   = reg_wr && hit(reg_addr, A_MARK);

    cfg_t              shadow_w, active_w;
    logic              pending_w, busy_w, avail_w, info_f1_w;
    logic [31:0]       info_addr_w;
    logic [DIM_W-1:0]  info_width_w, info_height_w;
    logic [CNT_W-1:0]  wr_count_w;
    logic [1:0]        irq_en_w, irq_flags_w;
    logic [LINE_W-1:0] line_mark_w;

    vfw_shadow_cfg u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_wr    (stage_wr),
        .stage_sel   (stage_sel),
        .wdata       (reg_wdata),
        .commit_wr   (commit_wr),
        .engine_busy (busy_w),
        .sof         (fld_sof),
        .shadow      (shadow_w),
        .active      (active_w),
        .pending     (pending_w)
    );

    vfw_field_track #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof         (fld_sof),
        .eof         (fld_eof),
        .ack_wr      (ack_wr),
        .commit_wr   (commit_wr),
        .fld_addr    (fld_addr),
        .fld_width   (fld_width),
        .fld_height  (fld_height),
        .fld_f1      (fld_f1),
        .busy        (busy_w),
        .avail       (avail_w),
        .info_addr   (info_addr_w),
        .info_width  (info_width_w),
        .info_height (info_height_w),
        .info_f1     (info_f1_w),
        .wr_count    (wr_count_w)
    );

    vfw_irq_ctrl #(.LINE_W(LINE_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (en_wr),
        .clr_wr     (clr_wr),
        .mark_wr    (mark_wr),
        .wdata      (reg_wdata),
        .field_done (fld_eof),
        .line_done  (line_done),
        .line_idx   (line_idx),
        .irq_en     (irq_en_w),
        .irq_flags  (irq_flags_w),
        .line_mark  (line_mark_w),
        .irq        (irq)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, A_ID))      reg_rdata = ID_WORD;
        if (hit(reg_addr, A_STAT))    reg_rdata = {30'd0, pending_w, busy_w};
        if (hit(reg_addr, A_IRQ_EN))  reg_rdata = {30'd0, irq_en_w};
        if (hit(reg_addr, A_IRQ_FLG)) reg_rdata = {30'd0, irq_flags_w};
        if (hit(reg_addr, A_RUN))     reg_rdata = {30'd0, shadow_w.run_mode};
        if (hit(reg_addr, A_BUFCNT))  reg_rdata = 32'(shadow_w.buf_count);
        if (hit(reg_addr, A_BASE))    reg_rdata = shadow_w.base;
        if (hit(reg_addr, A_BSTRIDE)) reg_rdata = shadow_w.buf_stride;
        if (hit(reg_addr, A_LSTRIDE)) reg_rdata = shadow_w.line_stride;
        if (hit(reg_addr, A_MARK))    reg_rdata = 32'(line_mark_w);
        if (hit(reg_addr, A_AVAIL))   reg_rdata = {31'd0, avail_w};
        if (hit(reg_addr, A_INF_ADR)) reg_rdata = info_addr_w;
        if (hit(reg_addr, A_INF_WID)) reg_rdata = 32'(info_width_w);
        if (hit(reg_addr, A_INF_HGT)) reg_rdata = 32'(info_height_w);
        if (hit(reg_addr, A_INF_F1))  reg_rdata = {31'd0, info_f1_w};
        if (hit(reg_addr, A_WRCOUNT)) reg_rdata = wr_count_w;
    end

    assign act_run_mode    = active_w.run_mode;
    assign act_buf_count   = active_w.buf_count;
    assign act_base        = active_w.base;
    assign act_buf_stride  = active_w.buf_stride;
    assign act_line_stride = active_w.line_stride;

endmodule

// File: rtl/vfw_ctrl_regs_chk.sv
module vfw_ctrl_regs_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              fld_sof,
    input logic              fld_eof,
    input logic              line_done,
    input logic              busy,
    input logic              pending,
    input logic              avail,
    input logic [31:0]       info_addr,
    input logic [31:0]       wr_count,
    input logic [31:0]       act_base,
    input logic [1:0]        act_run_mode,
    input logic              irq
);

    logic commit_w, ack_w, unmapped_w;
    assign commit_w   = reg_wr && (reg_addr == ADDR_W'('h28));
    assign ack_w      = reg_wr && (reg_addr == ADDR_W'('h2C));
    assign unmapped_w = reg_wr && ((reg_addr > ADDR_W'('h44)) || (reg_addr[1:0] != 2'b00));

    p_active_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fld_sof && !(commit_w && !busy)) |=> ($stable(act_base) && $stable(act_run_mode)));

    p_pending_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && !busy) |=> !pending);

    p_busy_sof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_sof && !fld_eof) |=> busy);

    p_info_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && !ack_w) |=> (avail && $stable(info_addr)));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && !fld_eof) |=> !avail);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fld_eof || line_done || reg_wr));

    p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |=> (wr_count == 32'd0));

    p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped_w && !pending) |=> !pending);

endmodule

bind vfw_ctrl_regs vfw_ctrl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .fld_sof      (fld_sof),
    .fld_eof      (fld_eof),
    .line_done    (line_done),
    .busy         (busy_w),
    .pending      (pending_w),
    .avail        (avail_w),
    .info_addr    (info_addr_w),
    .wr_count     (wr_count_w),
    .act_base     (act_base),
    .act_run_mode (act_run_mode),
    .irq          (irq)
);

// File: tb/vfw_ctrl_regs_tb.sv
module vfw_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fld_sof = 1'b0, fld_eof = 1'b0, line_done = 1'b0, fld_f1 = 1'b0;
    logic [15:0] line_idx = '0, fld_width = '0, fld_height = '0;
    logic [31:0] fld_addr = '0;
    logic [1:0]  act_run_mode;
    logic [23:0] act_buf_count;
    logic [31:0] act_base, act_buf_stride, act_line_stride;
    logic        irq;

    always #2 clk = ~clk;

    vfw_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fld_sof(fld_sof),
        .fld_eof(fld_eof), .line_done(line_done), .line_idx(line_idx),
        .fld_addr(fld_addr), .fld_width(fld_width), .fld_height(fld_height),
        .fld_f1(fld_f1), .act_run_mode(act_run_mode), .act_buf_count(act_buf_count),
        .act_base(act_base), .act_buf_stride(act_buf_stride),
        .act_line_stride(act_line_stride), .irq(irq)
    );

    int n_checks = 0;
    int n_fail = 0;

    // reference model
    logic [31:0] m_shd [5];
    logic [31:0] m_act [5];
    logic        m_pend, m_armed, m_busy, m_avail, m_f1;
    logic [31:0] m_iaddr, m_count;
    logic [15:0] m_iw, m_ih, m_mark;
    logic [1:0]  m_en, m_flg;

    localparam logic [31:0] FMASK [5] = '{32'h3, 32'hFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

    function automatic int stage_idx(input logic [7:0] a);
        case (a)
            8'h10: return 0;
            8'h14: return 1;
            8'h18: return 2;
            8'h1C: return 3;
            8'h20: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (stage_idx(a) >= 0) return m_shd[stage_idx(a)];
        case (a)
            8'h00: return 32'h5A17_03C1;
            8'h04: return {30'd0, m_pend, m_busy};
            8'h08: return {30'd0, m_en};
            8'h0C: return {30'd0, m_flg};
            8'h24: return {16'd0, m_mark};
            8'h30: return {31'd0, m_avail};
            8'h34: return m_iaddr;
            8'h38: return {16'd0, m_iw};
            8'h3C: return {16'd0, m_ih};
            8'h40: return {31'd0, m_f1};
            8'h44: return m_count;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h00: return "R8";
            8'h04: return "R2/R3";
            8'h08, 8'h0C, 8'h24: return "R6";
            8'h10, 8'h14, 8'h18, 8'h1C, 8'h20: return "R1";
            8'h30: return "R5";
            8'h34, 8'h38, 8'h3C, 8'h40: return "R4";
            8'h44: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_shd[i] = '0; m_act[i] = '0; end
        m_pend = 0; m_armed = 0; m_busy = 0; m_avail = 0; m_f1 = 0;
        m_iaddr = 0; m_count = 0; m_iw = 0; m_ih = 0; m_mark = 0; m_en = 0; m_flg = 0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] addrs [22] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                                  8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C,
                                  8'h40, 8'h44, 8'h48, 8'h06, 8'hFC, 8'h80};
        for (int i = 0; i < 22; i++) begin
            reg_addr = addrs[i];
            #1;
            check(req_of(addrs[i]), reg_rdata, exp_rd(addrs[i]), $sformatf("read %h", addrs[i]));
        end
        check("R1", {30'd0, act_run_mode}, m_act[0], "act_run_mode");
        check("R1", {8'd0, act_buf_count}, m_act[1], "act_buf_count");
        check("R1", act_base, m_act[2], "act_base");
        check("R1", act_buf_stride, m_act[3], "act_buf_stride");
        check("R1", act_line_stride, m_act[4], "act_line_stride");
        check("R6", {31'd0, irq}, {31'd0, |(m_flg & m_en)}, "irq");
    endtask

    // one clock cycle of stimulus, then model update from pre-cycle state
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic sof, input logic eof, input logic ln, input logic [15:0] li,
                         input logic [31:0] fa, input logic [15:0] fw, input logic [15:0] fh,
                         input logic f1);
        logic commit, ack, apply;
        logic [1:0] old_en;
        logic [15:0] old_mark;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; fld_sof = sof; fld_eof = eof;
        line_done = ln; line_idx = li; fld_addr = fa; fld_width = fw; fld_height = fh; fld_f1 = f1;
        @(negedge clk);
        reg_wr = 0; fld_sof = 0; fld_eof = 0; line_done = 0;
        commit = wr && a == 8'h28;
        ack    = wr && a == 8'h2C;
        apply  = (commit && !m_busy) || (sof && m_armed);
        old_en = m_en; old_mark = m_mark;
        if (commit && m_busy) m_armed = 1;
        if (apply) begin
            for (int i = 0; i < 5; i++) m_act[i] = m_shd[i];
            m_pend = 0; m_armed = 0;
        end
        if (wr && stage_idx(a) >= 0) begin
            m_shd[stage_idx(a)] = d & FMASK[stage_idx(a)];
            m_pend = 1;
        end
        if (sof) m_busy = 1;
        if (eof) m_busy = 0;
        if (eof && (!m_avail || ack)) begin
            m_iaddr = fa; m_iw = fw; m_ih = fh; m_f1 = f1;
        end
        if (ack) m_avail = 0;
        if (eof) m_avail = 1;
        if (eof) m_count = m_count + 1;
        if (commit) m_count = 0;
        if (wr && a == 8'h08) m_en = d[1:0];
        if (wr && a == 8'h24) m_mark = d[15:0];
        if (wr && a == 8'h0C) m_flg = m_flg & ~d[1:0];
        if (eof && old_en[0]) m_flg[0] = 1;
        if (ln && li == old_mark && old_en[1]) m_flg[1] = 1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        cycle(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic strobe(input logic sof, input logic eof, input logic [31:0] fa);
        cycle(0, 0, 0, sof, eof, 0, 0, fa, fa[15:0], fa[31:16], fa[0]);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all();                                   // reset state

        // R1/R2: staging holds off until commit; commit during a field waits for sof
        wr_reg(8'h18, 32'h1000_0000); check_all();
        wr_reg(8'h10, 32'h0000_0003); check_all();
        strobe(1, 0, 0); check_all();                  // R3 busy, not armed -> no apply
        wr_reg(8'h28, 32'h0);         check_all();     // commit while busy: pending stays
        strobe(0, 1, 32'h2222_0010); check_all();      // R4 capture, R7 count
        strobe(1, 0, 0); check_all();                  // applied here
        // R1: commit while idle
        strobe(0, 1, 32'h3333_0011); check_all();      // R4 frozen
        wr_reg(8'h1C, 32'h0004_0000); check_all();
        wr_reg(8'h28, 32'h1);         check_all();
        // R5: ack then ack + eof collision
        wr_reg(8'h2C, 32'h0);         check_all();
        strobe(0, 1, 32'h4444_0012); check_all();
        cycle(1, 8'h2C, 0, 0, 1, 0, 0, 32'h5555_0013, 16'h0780, 16'h0438, 1); check_all();
        // R6: interrupts
        wr_reg(8'h24, 32'd7);  wr_reg(8'h08, 32'h3); check_all();
        cycle(0, 0, 0, 0, 0, 1, 16'd6, 0, 0, 0, 0); check_all();
        cycle(0, 0, 0, 0, 0, 1, 16'd7, 0, 0, 0, 0); check_all();
        cycle(1, 8'h0C, 32'h3, 0, 1, 0, 0, 32'h6, 0, 0, 0); check_all(); // event beats clear
        wr_reg(8'h0C, 32'h3); check_all();
        // R9: unmapped writes
        wr_reg(8'h48, 32'hFFFF_FFFF); wr_reg(8'h11, 32'hFFFF_FFFF); check_all();

        // random mix
        void'($urandom(32'h00C0_FFEE));
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] r;
            op = $urandom % 11;
            r  = $urandom;
            case (op)
                0, 1: wr_reg(8'h10 + 8'(4 * ($urandom % 5)), r);
                2: wr_reg(8'h28, r);
                3: wr_reg(8'h2C, r);
                4: strobe(1, 0, r);
                5: strobe(0, 1, r);
                6: cycle(0, 0, 0, 0, 0, 1, m_mark + 16'($urandom % 2), 0, 0, 0, 0);
                7: wr_reg(8'h08, r);
                8: wr_reg(8'h0C, r);
                9: wr_reg((r[0]) ? 8'h4C : 8'h2A, r);
                default: cycle(1, 8'h2C, 0, 0, 1, 0, 0, r, r[31:16], r[15:0], r[3]);
            endcase
            check_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule